// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds two pending vectors with one bit per CPU. One vector records inter-processor interrupts and the other records interval-timer interrupts. Each bit drives an interrupt line to its CPU. Software posts and retires inter-processor interrupts, and retires timer interrupts, through a 2-bit register address. A single write carries a CPU bitmask, so it can reach several CPUs at once. A periodic tick input marks a timer interrupt pending on every CPU.

Register 0 is a combined control word. A write to it can post inter-processor interrupts, retire inter-processor interrupts and retire timer interrupts, all in one access. Registers 1 and 2 read back the inter-processor and timer vectors, and a write to either of them retires the masked bits. Register 3 posts inter-processor interrupts.

A post to a CPU that is already pending is reported on a one-cycle warning pulse and leaves the vector unchanged. A retire on a CPU that is not pending is reported on a separate warning pulse. A write that names no CPU at all raises a one-cycle error pulse and changes nothing.

Top module: `ipi_timer_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, both vectors, both interrupt outputs, `rdata`, `warn_dup_o`, `warn_idle_o` and `err_o` become zero.
- R2: A write to address 0 posts an inter-processor interrupt to each CPU n whose bit 12+n is set. `ipi_irq[n]` is high from the cycle after the write.
- R3: A write to address 0 retires the inter-processor interrupt of CPU n when bit 8+n is set, and the timer interrupt of CPU n when bit 4+n is set. When one write both posts and retires the same CPU, that CPU ends with nothing pending and no warning.
- R4: A write to address 0 that has bit 28 set and all of bits 15:4 clear is accepted with no state change and no error. A write to address 0 with bits 28 and 15:4 all clear raises `err_o` for one cycle and changes nothing.
- R5: A post to a CPU whose inter-processor bit is already set leaves that bit set and pulses `warn_dup_o` for one cycle.
- R6: A retire of an inter-processor interrupt on a CPU with none pending leaves the vector unchanged and pulses `warn_idle_o` for one cycle. This applies through both address 0 and address 1.
- R7: A cycle with `tick` high sets every bit of the timer vector. A timer retire in the same cycle wins for the CPUs it names.
- R8: A write to address 1 retires the inter-processor bits set in wdata[3:0]. A write to address 2 retires those timer bits. A write to address 3 posts inter-processor interrupts to those CPUs.
- R9: A write to address 1, 2 or 3 with wdata[3:0] all zero raises `err_o` for one cycle and changes no state.
- R10: `rdata` is loaded in the cycle after `rd_en` and holds otherwise, returning the state before any write in the same cycle. Each address reads as follows:
  - Address 0 returns the inter-processor vector in bits 11:8, the timer vector in bits 7:4 and `cpu_id` in bits 1:0.
  - Addresses 1 and 2 return their vector in bits 3:0.
  - Address 3 reads zero.
  - All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Periodic timer pulse, one cycle per period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| cpu_id | input | $clog2(NCPU) | Number of the CPU issuing the access |
| rdata | output | DATA_W | Registered read data |
| ipi_irq | output | NCPU | Inter-processor interrupt line per CPU |
| tmr_irq | output | NCPU | Timer interrupt line per CPU |
| warn_dup_o | output | 1 | Pulse: post to an already-pending CPU |
| warn_idle_o | output | 1 | Pulse: retire on a CPU with nothing pending |
| err_o | output | 1 | Pulse: write naming no CPU |

## Verification
The checker assumes the following about the inputs:
- Reset is held for at least two cycles.
- `addr`, `wdata` and `cpu_id` are meaningful only while a strobe is high.
- A tick lasts one cycle.

Under these assumptions, a vector bit may rise only in the cycle after a write or a tick, and the error and warning pulses may follow only a write. The stimulus drives every input on the falling edge and leaves all strobes low between accesses, so every rise seen at an edge traces back to a single access. A combined tick-and-retire cycle exercises the case where a timer retire and a tick meet on the same CPU.

// File: rtl/ipit_pkg.sv
package ipit_pkg;
  localparam int ADDR_W   = 2;
  localparam int FIELD_W  = 4;
  localparam int POST_LSB = 12;
  localparam int IRET_LSB = 8;
  localparam int TRET_LSB = 4;
  localparam int NXM_BIT  = 28;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_IPEND = 2'd1,
    SEL_TPEND = 2'd2,
    SEL_IPOST = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ipit_decode.sv
module ipit_decode
  import ipit_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCPU-1:0]   ipi_set,
  output logic [NCPU-1:0]   ipi_clr,
  output logic [NCPU-1:0]   tmr_clr,
  output logic              bad_wr
);
  reg_sel_e        sel;
  logic [NCPU-1:0] f_post, f_iret, f_tret, f_low;
  logic            nxm;
  logic            unused_bits;

  assign unused_bits = ^wdata;

  always_comb begin
    sel     = reg_sel_e'(addr);
    f_post  = wdata[POST_LSB +: NCPU];
    f_iret  = wdata[IRET_LSB +: NCPU];
    f_tret  = wdata[TRET_LSB +: NCPU];
    f_low   = wdata[0 +: NCPU];
    nxm     = wdata[NXM_BIT];
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    bad_wr  = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_CTRL: begin
          if (f_post == '0 && f_iret == '0 && f_tret == '0 && !nxm) begin
            bad_wr = 1'b1;
          end else begin
            ipi_set = f_post;
            ipi_clr = f_iret;
            tmr_clr = f_tret;
          end
        end
        SEL_IPEND: begin
          if (f_low == '0) bad_wr = 1'b1;
          else             ipi_clr = f_low;
        end
        SEL_TPEND: begin
          if (f_low == '0) bad_wr = 1'b1;
          else             tmr_clr = f_low;
        end
        SEL_IPOST: begin
          if (f_low == '0) bad_wr = 1'b1;
          else             ipi_set = f_low;
        end
      endcase
    end
  end
endmodule

// File: rtl/ipit_pend_vec.sv
module ipit_pend_vec #(
  parameter int NCPU    = 4,
  parameter bit WARN_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCPU-1:0] set_m,
  input  logic [NCPU-1:0] clr_m,
  output logic [NCPU-1:0] pend,
  output logic            dup_set,
  output logic            idle_clr
);
  for (genvar i = 0; i < NCPU; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (clr_m[i]) q <= 1'b0;
      else if (set_m[i]) q <= 1'b1;
    end
    assign pend[i] = q;
  end

  if (WARN_EN) begin : g_warn
    always_ff @(posedge clk) begin
      if (rst) begin
        dup_set  <= 1'b0;
        idle_clr <= 1'b0;
      end else begin
        dup_set  <= |(set_m & pend);
        idle_clr <= |(clr_m & ~(pend | set_m));
      end
    end
  end else begin : g_nowarn
    assign dup_set  = 1'b0;
    assign idle_clr = 1'b0;
  end
endmodule

// File: rtl/ipit_rdport.sv
module ipit_rdport
  import ipit_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic [NCPU-1:0]   ipi,
  input  logic [NCPU-1:0]   tmr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    unique case (reg_sel_e'(addr))
      SEL_CTRL: begin
        nxt[IRET_LSB +: NCPU] = ipi;
        nxt[TRET_LSB +: NCPU] = tmr;
        nxt[0 +: ID_W]        = cpu_id;
      end
      SEL_IPEND: nxt[0 +: NCPU] = ipi;
      SEL_TPEND: nxt[0 +: NCPU] = tmr;
      SEL_IPOST: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= nxt;
  end
endmodule

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl
  import ipit_pkg::*;
#(
  parameter  int NCPU   = 4,
  parameter  int DATA_W = 32,
  localparam int ID_W   = $clog2(NCPU)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   cpu_id,
  output logic [DATA_W-1:0] rdata,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq,
  output logic              warn_dup_o,
  output logic              warn_idle_o,
  output logic              err_o
);
  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
  logic            bad_wr;
  logic            tmr_unused_dup, tmr_unused_idle;

  ipit_decode #(.NCPU(NCPU), .DATA_W(DATA_W)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ipi_set(ipi_set), .ipi_clr(ipi_clr), .tmr_clr(tmr_clr), .bad_wr(bad_wr)
  );

  assign tmr_set = {NCPU{tick}};

  ipit_pend_vec #(.NCPU(NCPU), .WARN_EN(1'b1)) u_ipi (
    .clk(clk), .rst(rst), .set_m(ipi_set), .clr_m(ipi_clr),
    .pend(ipi_irq), .dup_set(warn_dup_o), .idle_clr(warn_idle_o)
  );

  ipit_pend_vec #(.NCPU(NCPU), .WARN_EN(1'b0)) u_tmr (
    .clk(clk), .rst(rst), .set_m(tmr_set), .clr_m(tmr_clr),
    .pend(tmr_irq), .dup_set(tmr_unused_dup), .idle_clr(tmr_unused_idle)
  );

  ipit_rdport #(.NCPU(NCPU), .DATA_W(DATA_W), .ID_W(ID_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cpu_id(cpu_id),
    .ipi(ipi_irq), .tmr(tmr_irq), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= bad_wr;
  end
endmodule

// File: rtl/ipit_checker.sv
module ipit_checker #(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [NCPU-1:0]   ipi_irq,
  input logic [NCPU-1:0]   tmr_irq,
  input logic              warn_dup_o,
  input logic              warn_idle_o,
  input logic              err_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ipi_irq == '0 && tmr_irq == '0 && !err_o && !warn_dup_o && !warn_idle_o));

  assert_ipi_rise_needs_write_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    ((ipi_irq & ~$past(ipi_irq)) != '0) |-> $past(wr_en));

  assert_ipi_idle_stable_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(wr_en) |-> $stable(ipi_irq));

  assert_tick_fills_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(tick) && !$past(wr_en)) |-> (&tmr_irq));

  assert_tmr_rise_needs_tick_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    ((tmr_irq & ~$past(tmr_irq)) != '0) |-> $past(tick));

  assert_err_after_write_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    err_o |-> $past(wr_en));

  assert_err_keeps_ipi_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    err_o |-> $stable(ipi_irq));

  assert_warn_after_write_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (warn_dup_o || warn_idle_o) |-> $past(wr_en));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind ipi_timer_ctl ipit_checker #(.NCPU(NCPU), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
  .warn_dup_o(warn_dup_o), .warn_idle_o(warn_idle_o), .err_o(err_o)
);

// File: tb/ipi_timer_ctl_test.sv
`timescale 1ns/1ps
module ipi_timer_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  cpu_id = '0;
  logic [31:0] rdata;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        warn_dup_o, warn_idle_o, err_o;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipi_timer_ctl uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .cpu_id(cpu_id), .rdata(rdata),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn_dup_o(warn_dup_o),
    .warn_idle_o(warn_idle_o), .err_o(err_o)
  );

  // Behavioural reference model
  logic [3:0]  m_ipi = '0, m_tmr = '0;
  logic        m_dup = 0, m_idle = 0, m_err = 0, live = 0;
  logic [31:0] m_rd = '0;

  always @(posedge clk) begin
    logic [3:0] post, iret, tret;
    live = !rst;
    if (rst) begin
      m_ipi = '0; m_tmr = '0; m_dup = 0; m_idle = 0; m_err = 0; m_rd = '0;
    end else begin
      if (rd_en) begin
        case (addr)
          2'd0: m_rd = (32'(m_ipi) << 8) | (32'(m_tmr) << 4) | 32'(cpu_id);
          2'd1: m_rd = 32'(m_ipi);
          2'd2: m_rd = 32'(m_tmr);
          default: m_rd = '0;
        endcase
      end
      m_dup = 0; m_idle = 0; m_err = 0;
      post = '0; iret = '0; tret = '0;
      if (wr_en) begin
        if (addr == 2'd0) begin
          post = wdata[15:12]; iret = wdata[11:8]; tret = wdata[7:4];
          if (post == 0 && iret == 0 && tret == 0 && !wdata[28]) m_err = 1;
        end else if (wdata[3:0] == 0) m_err = 1;
        else if (addr == 2'd1) iret = wdata[3:0];
        else if (addr == 2'd2) tret = wdata[3:0];
        else post = wdata[3:0];
      end
      for (int i = 0; i < 4; i++)
        if (post[i]) begin if (m_ipi[i]) m_dup = 1; else m_ipi[i] = 1; end
      for (int i = 0; i < 4; i++)
        if (iret[i]) begin if (m_ipi[i]) m_ipi[i] = 0; else m_idle = 1; end
      if (tick) m_tmr = 4'hF;
      for (int i = 0; i < 4; i++) if (tret[i]) m_tmr[i] = 0;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk(32'(ipi_irq), 32'(m_ipi), "R2 model ipi");
      chk(32'(tmr_irq), 32'(m_tmr), "R7 model tmr");
      chk(32'(warn_dup_o), 32'(m_dup), "R5 model dup");
      chk(32'(warn_idle_o), 32'(m_idle), "R6 model idle");
      chk(32'(err_o), 32'(m_err), "R9 model err");
      chk(rdata, m_rd, "R10 model rdata");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #80000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(32'(ipi_irq), 0, "R1 ipi"); chk(32'(tmr_irq), 0, "R1 tmr");
    chk(rdata, 0, "R1 rdata"); chk(32'(err_o), 0, "R1 err");
    // R2 post CPUs 0 and 2
    wr(2'd0, 32'h0000_5000);
    chk(32'(ipi_irq), 32'h5, "R2 post");
    // R5 duplicate post
    wr(2'd0, 32'h0000_1000);
    chk(32'(ipi_irq), 32'h5, "R5 unchanged"); chk(32'(warn_dup_o), 1, "R5 pulse");
    @(negedge clk);
    chk(32'(warn_dup_o), 0, "R5 pulse ends");
    // R6 retire of idle CPU1
    wr(2'd0, 32'h0000_0200);
    chk(32'(ipi_irq), 32'h5, "R6 unchanged"); chk(32'(warn_idle_o), 1, "R6 pulse");
    // R3 post and retire CPU3 together
    wr(2'd0, 32'h0000_8800);
    chk(32'(ipi_irq), 32'h5, "R3 combined");
    chk(32'(warn_dup_o | warn_idle_o), 0, "R3 no warn");
    // R7 tick
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk(32'(tmr_irq), 32'hF, "R7 tick");
    // R3 timer retire CPUs 0,1
    wr(2'd0, 32'h0000_0030);
    chk(32'(tmr_irq), 32'hC, "R3 timer retire");
    // R7 tick with retire of CPU2 in same cycle
    tick = 1'b1; wr(2'd2, 32'h4); tick = 1'b0;
    chk(32'(tmr_irq), 32'hB, "R7 retire wins");
    // R10 reads
    cpu_id = 2'd2;
    rd(2'd0); chk(rdata, 32'h0000_05B2, "R10 ctrl read");
    rd(2'd1); chk(rdata, 32'h5, "R10 ipi read");
    rd(2'd2); chk(rdata, 32'hB, "R10 tmr read");
    rd(2'd3); chk(rdata, 32'h0, "R10 post reg read");
    @(negedge clk); chk(rdata, 32'h0, "R10 hold");
    // R4 nxm-only and empty writes
    wr(2'd0, 32'h1000_0000);
    chk(32'(err_o), 0, "R4 nxm accepted"); chk(32'(ipi_irq), 32'h5, "R4 nxm no change");
    wr(2'd0, 32'h0000_000F);
    chk(32'(err_o), 1, "R4 empty err"); chk(32'(tmr_irq), 32'hB, "R4 empty no change");
    // R8 dedicated registers
    wr(2'd3, 32'h2); chk(32'(ipi_irq), 32'h7, "R8 post reg");
    wr(2'd1, 32'h5); chk(32'(ipi_irq), 32'h2, "R8 ipi retire reg");
    wr(2'd2, 32'h8); chk(32'(tmr_irq), 32'h3, "R8 tmr retire reg");
    // R9 zero masks
    wr(2'd3, 32'h10); chk(32'(err_o), 1, "R9 post zero"); chk(32'(ipi_irq), 32'h2, "R9 no change");
    wr(2'd1, 32'h0);  chk(32'(err_o), 1, "R9 ipi retire zero");
    wr(2'd2, 32'hF0); chk(32'(err_o), 1, "R9 tmr retire zero"); chk(32'(tmr_irq), 32'h3, "R9 tmr kept");
    // R6 through dedicated register
    wr(2'd1, 32'h1); chk(32'(warn_idle_o), 1, "R6 dedicated idle"); chk(32'(ipi_irq), 32'h2, "R6 kept");
    // R1 reset mid-run
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk(32'(ipi_irq), 0, "R1 rerun ipi"); chk(32'(tmr_irq), 0, "R1 rerun tmr");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule